// File: doc/BRIEF.md
# Keypad Scancode Scanner

This block turns a stream of keyboard scancode bytes into calculator key events. Each byte comes with a one-cycle valid strobe. The block keeps only the keys a calculator front end needs: the keypad digits, the four keypad operators, space, backspace and enter. It passes each recognised key on through one of three handshakes.

Printable keys go to a line-history store as an ASCII byte under a take/done handshake. Backspace goes to the same store as its own request. Enter starts an expression evaluator under a start/finished handshake. Extended-key prefixes and key-release prefixes are tracked, so each key acts once per press. The two-byte keypad divide is recognised. Only one request is outstanding at a time. Bytes that arrive while a request is pending are discarded.

Top module: `kp_scanner`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle after that edge. `chr_take`, `bksp_req` and `exec_req` are low, and both the extended and the release prefix flags are cleared.
- R2: A byte on `code` is acted on only at a clock edge where `code_vld` is high. A valid code held with `code_vld` low produces no request.
- R3: Keypad digit codes 0x70, 0x69, 0x72, 0x7A, 0x6B, 0x73, 0x74, 0x6C, 0x75 and 0x7D (digits 0 to 9 in that order) raise `chr_take` one cycle after the strobe edge. `chr_out` then holds 0x30 to 0x39.
- R4: The codes 0x79 (plus), 0x7B (minus), 0x7C (multiply) and 0x29 (space) raise `chr_take` with `chr_out` set to 0x2B, 0x2D, 0x2A and 0x20.
- R5: 0xE0 followed by 0x4A raises `chr_take` with `chr_out` = 0x2F. 0xE0 alone raises nothing. 0x4A without the prefix raises nothing.
- R6: `chr_take` and `chr_out` stay unchanged until `chr_done` is high at a clock edge. `chr_take` is low after that edge.
- R7: Code 0x66 raises `bksp_req` (not `chr_take`). `bksp_req` stays high until `chr_done` is sampled high, and is low after that edge.
- R8: Code 0x5A raises `exec_req`. `exec_req` stays high, however long the wait, until `exec_fin` is sampled high, and is low after that edge.
- R9: After 0xF0, the next strobed byte is consumed with no request. E0 F0 4A raises nothing. The flags are cleared afterwards, so the next press acts normally.
- R10: Any other code raises no request, and so does an E0-prefixed code other than 0x4A.
- R11: Strobed bytes that arrive while a request is pending are discarded and leave the prefix flags unchanged. A prefix sent during a pending request does not affect the next byte.
- R12: At most one of `chr_take`, `bksp_req` and `exec_req` is high at any time. A request rises only in the cycle after a strobed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_vld | input | 1 | One-cycle strobe qualifying `code` |
| code | input | 8 | Scancode byte |
| chr_out | output | 8 | ASCII byte of the pending printable key |
| chr_take | output | 1 | Printable character request to history |
| chr_done | input | 1 | History acknowledge for character or backspace |
| bksp_req | output | 1 | Backspace request to history |
| exec_req | output | 1 | Start request to the evaluator |
| exec_fin | input | 1 | Evaluator completion |

## Verification
The bench targets the prefix corner cases. A design that let a lone 0xE0 or an unprefixed 0x4A through would emit a stray '/'. A design that failed to clear the release flag would swallow the key pressed after a release. Bytes strobed during a pending handshake, including 0xF0 and 0xE0, are aimed at a design that queues them or lets them set prefix flags; such a design would emit extra characters or drop the next real key. Long acknowledge delays on both handshakes expose a request that drops early, or a character byte that changes while the request is held.

// File: rtl/kp_scanner.sv
module kp_scanner #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          code_vld,
  input  logic [CW-1:0] code,
  output logic [7:0]    chr_out,
  output logic          chr_take,
  input  logic          chr_done,
  output logic          bksp_req,
  output logic          exec_req,
  input  logic          exec_fin
);
  localparam logic [CW-1:0] PFX_EXT = CW'('hE0);
  localparam logic [CW-1:0] PFX_REL = CW'('hF0);
  localparam logic [CW-1:0] K_DIV   = CW'('h4A);

  typedef enum logic [1:0] {S_IDLE, S_CHR, S_BKSP, S_EXEC} st_t;
  typedef enum logic [1:0] {K_NONE, K_CHR, K_BKSP, K_EXEC} kind_t;

  st_t   st;
  logic  ext_f, rel_f;
  kind_t kind;
  logic [7:0] asc;

  always_comb begin
    kind = K_NONE;
    asc  = 8'h00;
    if (ext_f) begin
      if (code == K_DIV) begin kind = K_CHR; asc = 8'h2F; end
    end else begin
      case (code)
        CW'('h70): begin kind = K_CHR; asc = 8'h30; end
        CW'('h69): begin kind = K_CHR; asc = 8'h31; end
        CW'('h72): begin kind = K_CHR; asc = 8'h32; end
        CW'('h7A): begin kind = K_CHR; asc = 8'h33; end
        CW'('h6B): begin kind = K_CHR; asc = 8'h34; end
        CW'('h73): begin kind = K_CHR; asc = 8'h35; end
        CW'('h74): begin kind = K_CHR; asc = 8'h36; end
        CW'('h6C): begin kind = K_CHR; asc = 8'h37; end
        CW'('h75): begin kind = K_CHR; asc = 8'h38; end
        CW'('h7D): begin kind = K_CHR; asc = 8'h39; end
        CW'('h79): begin kind = K_CHR; asc = 8'h2B; end
        CW'('h7B): begin kind = K_CHR; asc = 8'h2D; end
        CW'('h7C): begin kind = K_CHR; asc = 8'h2A; end
        CW'('h29): begin kind = K_CHR; asc = 8'h20; end
        CW'('h66): kind = K_BKSP;
        CW'('h5A): kind = K_EXEC;
        default:   kind = K_NONE;
      endcase
    end
  end

  wire idle = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ext_f   <= 1'b0;
      rel_f   <= 1'b0;
      chr_out <= 8'h00;
    end else begin
      case (st)
        S_IDLE: if (code_vld) begin
          if (code == PFX_EXT) begin
            ext_f <= 1'b1;
          end else if (code == PFX_REL) begin
            rel_f <= 1'b1;
          end else begin
            ext_f <= 1'b0;
            rel_f <= 1'b0;
            if (!rel_f) begin
              case (kind)
                K_CHR:   begin st <= S_CHR; chr_out <= asc; end
                K_BKSP:  st <= S_BKSP;
                K_EXEC:  st <= S_EXEC;
                default: st <= S_IDLE;
              endcase
            end
          end
        end
        S_CHR, S_BKSP: if (chr_done) st <= S_IDLE;
        S_EXEC:        if (exec_fin) st <= S_IDLE;
        default:       st <= S_IDLE;
      endcase
    end
  end

  assign chr_take = (st == S_CHR);
  assign bksp_req = (st == S_BKSP);
  assign exec_req = (st == S_EXEC) && !idle;
endmodule

// File: rtl/kp_scanner_chk.sv
module kp_scanner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       code_vld,
  input logic [7:0] chr_out,
  input logic       chr_take,
  input logic       chr_done,
  input logic       bksp_req,
  input logic       exec_req,
  input logic       exec_fin
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !(chr_take || bksp_req || exec_req));

  // R12
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chr_take, bksp_req, exec_req}));

  // R12
  req_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(chr_take) || $rose(bksp_req) || $rose(exec_req)) |-> $past(code_vld));

  // R6
  take_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_take && !chr_done) |=> (chr_take && $stable(chr_out)));

  // R6
  take_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_take && chr_done) |=> !chr_take);

  // R7
  bksp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bksp_req && !chr_done) |=> bksp_req);

  // R7
  bksp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bksp_req && chr_done) |=> !bksp_req);

  // R8
  exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_req && !exec_fin) |=> exec_req);

  // R8
  exec_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_req && exec_fin) |=> !exec_req);
endmodule

bind kp_scanner kp_scanner_chk chk_i (
  .clk(clk), .rst_n(rst_n), .code_vld(code_vld), .chr_out(chr_out),
  .chr_take(chr_take), .chr_done(chr_done), .bksp_req(bksp_req),
  .exec_req(exec_req), .exec_fin(exec_fin)
);

// File: tb/kp_scanner_test.sv
module kp_scanner_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       code_vld = 1'b0;
  logic [7:0] code = 8'h00;
  logic       chr_done = 1'b0;
  logic       exec_fin = 1'b0;
  logic [7:0] chr_out;
  logic       chr_take, bksp_req, exec_req;

  int tests = 0, fails = 0, cyc = 0;
  bit armed = 0;
  string tag = "R1";

  int m_busy = 0, m_chr = 0;
  bit m_ext = 0, m_rel = 0;

  kp_scanner uut (
    .clk(clk), .rst_n(rst_n), .code_vld(code_vld), .code(code),
    .chr_out(chr_out), .chr_take(chr_take), .chr_done(chr_done),
    .bksp_req(bksp_req), .exec_req(exec_req), .exec_fin(exec_fin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // returns ASCII for printable, -2 backspace, -3 enter, -1 nothing
  function automatic int key_of(int c, bit ext);
    int dig[10] = '{'h70, 'h69, 'h72, 'h7A, 'h6B, 'h73, 'h74, 'h6C, 'h75, 'h7D};
    if (ext) return (c == 'h4A) ? 'h2F : -1;
    for (int i = 0; i < 10; i++) if (dig[i] == c) return 'h30 + i;
    case (c)
      'h79: return 'h2B;
      'h7B: return 'h2D;
      'h7C: return 'h2A;
      'h29: return 'h20;
      'h66: return -2;
      'h5A: return -3;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ext = 0; m_rel = 0;
    end else if (m_busy != 0) begin
      if ((m_busy < 3 && chr_done) || (m_busy == 3 && exec_fin)) m_busy = 0;
    end else if (code_vld) begin
      if (code == 8'hE0) m_ext = 1;
      else if (code == 8'hF0) m_rel = 1;
      else begin
        int k;
        k = key_of(code, m_ext);
        if (!m_rel) begin
          if (k >= 0) begin m_busy = 1; m_chr = k; end
          else if (k == -2) m_busy = 2;
          else if (k == -3) m_busy = 3;
        end
        m_ext = 0; m_rel = 0;
      end
    end
  end

  task automatic chk(bit ok, string t, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) if (armed) begin
    chk(chr_take == (m_busy == 1), tag, "chr_take", chr_take, m_busy == 1);
    chk(bksp_req == (m_busy == 2), tag, "bksp_req", bksp_req, m_busy == 2);
    chk(exec_req == (m_busy == 3), tag, "exec_req", exec_req, m_busy == 3);
    if (m_busy == 1) chk(chr_out == m_chr[7:0], tag, "chr_out", chr_out, m_chr);
    chk($onehot0({chr_take, bksp_req, exec_req}), "R12", "req count",
        $countones({chr_take, bksp_req, exec_req}), 1);
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL %s watchdog: actual cycle %0d expected completion earlier", tag, cyc);
      summary();
    end
  end

  task automatic send(logic [7:0] c);
    @(posedge clk); #1; code_vld = 1; code = c;
    @(posedge clk); #1; code_vld = 0; code = 8'h70;
  endtask

  task automatic exp_none(string t);
    @(negedge clk);
    chk(!(chr_take || bksp_req || exec_req), t, "no request",
        {chr_take, bksp_req, exec_req}, 0);
  endtask

  task automatic exp_chr(int a, string t);
    @(negedge clk);
    chk(chr_take && !bksp_req && !exec_req, t, "take", chr_take, 1);
    chk(chr_out == a[7:0], t, "ascii", chr_out, a);
  endtask

  task automatic serve(int d);
    bit ex;
    ex = exec_req;
    repeat (d) @(posedge clk);
    #1; if (ex) exec_fin = 1; else chr_done = 1;
    @(posedge clk); #1; exec_fin = 0; chr_done = 0;
  endtask

  initial begin
    int dig[10] = '{'h70, 'h69, 'h72, 'h7A, 'h6B, 'h73, 'h74, 'h6C, 'h75, 'h7D};
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    armed = 1;
    tag = "R1"; exp_none("R1");

    tag = "R2";
    code = 8'h70;
    repeat (4) exp_none("R2");

    tag = "R3";
    for (int i = 0; i < 10; i++) begin
      send(dig[i][7:0]); exp_chr('h30 + i, "R3"); serve(i % 4);
    end

    tag = "R4";
    send(8'h79); exp_chr('h2B, "R4"); serve(0);
    send(8'h7B); exp_chr('h2D, "R4"); serve(1);
    send(8'h7C); exp_chr('h2A, "R4"); serve(2);
    send(8'h29); exp_chr('h20, "R4"); serve(0);

    tag = "R5";
    send(8'hE0); exp_none("R5");
    send(8'h4A); exp_chr('h2F, "R5"); serve(1);
    send(8'h4A); exp_none("R5");

    tag = "R6";
    send(8'h75); exp_chr('h38, "R6");
    repeat (6) exp_chr('h38, "R6");
    serve(0); exp_none("R6");

    tag = "R7";
    send(8'h66); @(negedge clk);
    chk(bksp_req && !chr_take, "R7", "bksp_req", bksp_req, 1);
    repeat (5) @(negedge clk);
    chk(bksp_req, "R7", "bksp held", bksp_req, 1);
    serve(0); exp_none("R7");

    tag = "R8";
    send(8'h5A); @(negedge clk);
    chk(exec_req, "R8", "exec_req", exec_req, 1);
    repeat (40) @(negedge clk);
    chk(exec_req, "R8", "exec held", exec_req, 1);
    serve(0); exp_none("R8");

    tag = "R9";
    send(8'hF0); send(8'h70); exp_none("R9");
    send(8'h70); exp_chr('h30, "R9"); serve(0);
    send(8'hE0); send(8'hF0); send(8'h4A); exp_none("R9");
    send(8'h73); exp_chr('h35, "R9"); serve(0);

    tag = "R10";
    send(8'h1C); exp_none("R10");
    send(8'h12); exp_none("R10");
    send(8'hE0); send(8'h5A); exp_none("R10");

    tag = "R11";
    send(8'h72); exp_chr('h32, "R11");
    send(8'h69); exp_chr('h32, "R11");
    send(8'hF0); send(8'hE0); exp_chr('h32, "R11");
    serve(0);
    send(8'h74); exp_chr('h36, "R11"); serve(0);
    send(8'h5A); send(8'hE0); send(8'h66); serve(2);
    send(8'h4A); exp_none("R11");

    tag = "R1";
    send(8'h7D); @(posedge clk); #1; rst_n = 0;
    @(posedge clk); #1; rst_n = 1;
    exp_none("R1");
    send(8'hF0); @(posedge clk); #1; rst_n = 0;
    @(posedge clk); #1; rst_n = 1;
    send(8'h6C); exp_chr('h37, "R1"); serve(0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule